// File: doc/BRIEF.md
# Commutation Blanking and Watchdog Timer

This block guards the back-EMF sensing path of a sensorless three-phase motor drive. One counter restarts at every commutation, whether the sequencer issued it or this block forced it. The block compares that counter against two thresholds. Below the low threshold the comparator output is hidden from the rest of the controller, so the ringing that follows each output switch cannot pass as a zero crossing. The higher threshold sets a deadline for the expected back-EMF polarity.

If the comparator does not show the polarity the current state expects somewhere between the end of blanking and the deadline, the block emits a one-clock forced-commutation pulse. This pulse steps the sequencer to its next state. The same pulse restarts the counter inside the block. Repeated forced steps pull a reversing or free-wheeling rotor back into step, and they also serve as the start-up drive. Both windows are counted in the same clock, so both scale from one base.

The two thresholds come from configuration inputs and are registered inside the block. A low threshold that is not below the high one is flagged and pulled down to one count under the high threshold.

Top module: `commutation_guard`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, blank_o, force_comm_o and thr_err_o are 0, the watchdog is disarmed, and cmp_masked_o follows bemf_cmp_i.
- R2: A commutation (commutate_i high at an edge, or a forced pulse) clears the counter. blank_o is then high for exactly L cycles after that edge, where L is the effective low threshold.
- R3: While blank_o is high, cmp_masked_o is 0. Otherwise it equals bemf_cmp_i.
- R4: If bemf_cmp_i never equals expect_pol_i while the counter value k lies in the range L <= k <= H, force_comm_o is high during the cycle that follows the (H+1)-th edge after the commutation edge. H is the high threshold.
- R5: force_comm_o lasts one cycle and restarts the counter. With no matching polarity, forced pulses repeat every H+2 cycles, and blanking re-asserts after each one.
- R6: Once a match is seen outside blanking, no forced pulse occurs until the next commutation. The counter then holds at H and does not wrap.
- R7: A polarity match seen while blank_o is high does not disarm the watchdog.
- R8: A commutate_i at the same edge at which the deadline would fire restarts the counter and suppresses the forced pulse.
- R9: thr_err_o is 1 exactly when the registered low threshold is not below the high threshold. In that case L is H-1, or 0 when H is 0. Threshold inputs take effect one edge after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| commutate_i | input | 1 | Normal commutation event from the sequencer, one cycle |
| bemf_cmp_i | input | 1 | Back-EMF comparator output |
| expect_pol_i | input | 1 | Polarity expected for the present state |
| blank_thr_i | input | CNT_W | Requested blanking length in cycles |
| wd_thr_i | input | CNT_W | Watchdog deadline count |
| blank_o | output | 1 | Blanking window active |
| cmp_masked_o | output | 1 | Comparator output, held at 0 while blanking |
| force_comm_o | output | 1 | One-cycle forced commutation request |
| thr_err_o | output | 1 | Threshold ordering error |

## Verification
Some properties are checked on every cycle by the assertions. A restart leaves the counter at zero. A saturated counter holds while the deadline is stable. A forced pulse never lasts two cycles. A forced pulse never follows a normal commutation. No pulse occurs inside blanking. The clamped low threshold always stays below the high one.

Other behaviour can only be shown by the bench's scenarios. These are the exact cycle on which the pulse appears for a given match position. They include a match ignored inside blanking and one accepted on the deadline count itself. They also cover the spacing of repeated forced steps, the suppression by a coincident normal commutation, and the effective blank length after clamping.

// File: rtl/cg_pkg.sv
// Shared types for the commutation guard.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package cg_pkg;

    // Where the shared counter sits relative to the two thresholds.
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,  // no commutation seen since reset
        PH_BLANK    = 2'd1,  // counter below the low threshold
        PH_CHECK    = 2'd2,  // between the thresholds
        PH_DEADLINE = 2'd3   // counter at or above the high threshold
    } cg_phase_e;

endpackage

// File: rtl/cg_thresh_cfg.sv
// Threshold register stage.
// Registers the requested low and high counts. When the low count is not
// strictly below the high count, it raises an error flag and pulls the low
// count to one under the high count (or to 0 when the high count is 0).
// Assumes: the inputs are quasi-static configuration values.
module cg_thresh_cfg #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DEF_LO = 4,
    parameter int unsigned DEF_HI = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] lo_req_i,
    input  logic [CNT_W-1:0] hi_req_i,
    output logic [CNT_W-1:0] lo_o,
    output logic [CNT_W-1:0] hi_o,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] RST_LO = CNT_W'(DEF_LO);
    localparam logic [CNT_W-1:0] RST_HI = CNT_W'(DEF_HI);

    logic             order_ok;
    logic [CNT_W-1:0] lo_fix;

    // Purpose: decide the ordering and the clamped low value.
    always_comb begin
        order_ok = (lo_req_i < hi_req_i);
        if (order_ok)
            lo_fix = lo_req_i;
        else if (hi_req_i == '0)
            lo_fix = '0;
        else
            lo_fix = hi_req_i - ONE;
    end

    // Purpose: hold the effective thresholds and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o  <= RST_LO;
            hi_o  <= RST_HI;
            err_o <= 1'b0;
        end else begin
            lo_o  <= lo_fix;
            hi_o  <= hi_req_i;
            err_o <= !order_ok;
        end
    end

    // R9: the effective low threshold stays under a nonzero high threshold.
    p_lo_below_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_o != '0) |-> (lo_o < hi_o));

endmodule

// File: rtl/cg_timer.sv
// Shared commutation timer.
// Clears on every restart and counts up once per clock. It saturates at
// the high threshold and never wraps. active_o marks that at least one
// restart has occurred since reset.
// Assumes: restart_i is already the OR of normal and forced events.
module cg_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Purpose: restart, count or hold the shared timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o    <= '0;
            active_o <= 1'b0;
        end else if (restart_i) begin
            cnt_o    <= '0;
            active_o <= 1'b1;
        end else if (active_o && (cnt_o < hi_i)) begin
            cnt_o    <= cnt_o + ONE;
        end
    end

    // R2: a restart leaves the counter at zero and the timer running.
    p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> ((cnt_o == '0) && active_o));

    // R6: a saturated counter holds while the deadline does not move.
    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && active_o && (cnt_o >= hi_i) && $stable(hi_i))
        |=> $stable(cnt_o));

endmodule

// File: rtl/cg_window.sv
// Window decode and watchdog.
// Maps the counter onto the blank, check and deadline phases and masks
// the comparator output while blanking. It arms at each restart and
// disarms on a polarity match outside blanking. At the deadline with no
// match it issues a one-cycle forced commutation, unless a normal
// commutation arrives on that same edge.
// Assumes: lo_i < hi_i, or both are zero, as cg_thresh_cfg guarantees.
module cg_window
    import cg_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter bit          MASK_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commutate_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic             cmp_i,
    input  logic             pol_i,
    output logic             blank_o,
    output logic             masked_o,
    output logic             force_o
);

    cg_phase_e phase;
    logic      armed_q;
    logic      seen;
    logic      expire;
    logic      restart;

    // Purpose: place the counter in one of the four phases.
    always_comb begin
        if (!active_i)
            phase = PH_IDLE;
        else if (cnt_i < lo_i)
            phase = PH_BLANK;
        else if (cnt_i < hi_i)
            phase = PH_CHECK;
        else
            phase = PH_DEADLINE;
    end

    // Purpose: blank flag and the watchdog match / expiry decisions.
    always_comb begin
        blank_o = (phase == PH_BLANK);
        seen    = armed_q && ((phase == PH_CHECK) || (phase == PH_DEADLINE))
                  && (cmp_i == pol_i);
        expire  = armed_q && (phase == PH_DEADLINE) && !seen && !commutate_i;
        restart = commutate_i || force_o;
    end

    // Select the masked level chosen by the parameter.
    generate
        if (MASK_VAL) begin : g_mask_high
            assign masked_o = blank_o ? 1'b1 : cmp_i;
        end else begin : g_mask_low
            assign masked_o = blank_o ? 1'b0 : cmp_i;
        end
    endgenerate

    // Purpose: arm at each restart, disarm on a match or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (restart)
            armed_q <= 1'b1;
        else if (seen || expire)
            armed_q <= 1'b0;
    end

    // Purpose: register the one-cycle forced commutation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            force_o <= 1'b0;
        else
            force_o <= expire;
    end

    // R5: a forced pulse never lasts two cycles.
    p_force_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_o |=> !force_o);

    // R8: a normal commutation is never followed by a forced pulse.
    p_commutate_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commutate_i |=> !force_o);

    // R7: no forced pulse while the comparator is blanked.
    p_no_force_in_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> !force_o);

    // R5: the watchdog is disarmed while its own pulse is out.
    p_disarm_on_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_o |-> !armed_q);

endmodule

// File: rtl/commutation_guard.sv
// Commutation blanking and watchdog timer, top level.
// One shared counter restarts on every normal or forced commutation. A
// low threshold sets the comparator blanking window. A high threshold sets
// the deadline for the expected back-EMF polarity. A missed deadline
// yields a one-cycle forced commutation, which is also fed back as a
// restart.
// Assumes: commutate_i is a single-cycle pulse synchronous to clk.
module commutation_guard #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned DEF_LO   = 4,
    parameter int unsigned DEF_HI   = 32,
    parameter bit          MASK_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commutate_i,
    input  logic             bemf_cmp_i,
    input  logic             expect_pol_i,
    input  logic [CNT_W-1:0] blank_thr_i,
    input  logic [CNT_W-1:0] wd_thr_i,
    output logic             blank_o,
    output logic             cmp_masked_o,
    output logic             force_comm_o,
    output logic             thr_err_o
);

    logic [CNT_W-1:0] lo_eff;
    logic [CNT_W-1:0] hi_eff;
    logic [CNT_W-1:0] cnt;
    logic             active;
    logic             restart;

    // Purpose: a normal or a forced commutation restarts the timer.
    always_comb restart = commutate_i || force_comm_o;

    cg_thresh_cfg #(
        .CNT_W  (CNT_W),
        .DEF_LO (DEF_LO),
        .DEF_HI (DEF_HI)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_req_i (blank_thr_i),
        .hi_req_i (wd_thr_i),
        .lo_o     (lo_eff),
        .hi_o     (hi_eff),
        .err_o    (thr_err_o)
    );

    cg_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .hi_i      (hi_eff),
        .cnt_o     (cnt),
        .active_o  (active)
    );

    cg_window #(
        .CNT_W    (CNT_W),
        .MASK_VAL (MASK_VAL)
    ) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .commutate_i (commutate_i),
        .cnt_i       (cnt),
        .active_i    (active),
        .lo_i        (lo_eff),
        .hi_i        (hi_eff),
        .cmp_i       (bemf_cmp_i),
        .pol_i       (expect_pol_i),
        .blank_o     (blank_o),
        .masked_o    (cmp_masked_o),
        .force_o     (force_comm_o)
    );

    // R3: while blanking, the masked output shows the fixed level.
    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> (cmp_masked_o == MASK_VAL));

    // R1: blanking only ever follows a commutation since reset.
    p_blank_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> active);

endmodule

// File: tb/sim_commutation_guard.sv
module sim_commutation_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       comm = 1'b0;
    logic       cmp = 1'b0;
    logic       pol = 1'b1;
    logic [7:0] lo = 8'd4;
    logic [7:0] hi = 8'd32;
    logic       blank, masked, force_c, err;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    commutation_guard u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .commutate_i  (comm),
        .bemf_cmp_i   (cmp),
        .expect_pol_i (pol),
        .blank_thr_i  (lo),
        .wd_thr_i     (hi),
        .blank_o      (blank),
        .cmp_masked_o (masked),
        .force_comm_o (force_c),
        .thr_err_o    (err)
    );

    // Vectors {low, high, match position}; 8'hFF = no match at all.
    localparam logic [23:0] VEC [0:9] = '{
        24'h03_08_FF,  // R4 no match -> forced
        24'h03_08_05,  // R6 match in check window
        24'h03_08_01,  // R7 match only inside blanking -> forced
        24'h03_08_08,  // R4 match on deadline count -> not forced
        24'h03_08_03,  // R6 match on first unblanked count
        24'h00_04_00,  // R2 zero blanking
        24'h06_04_FF,  // R9 clamp, forced
        24'h05_05_FF,  // R9 equal thresholds
        24'h02_02_01,  // R9 clamp to 1, match at 1
        24'h01_0C_FF   // R4 long deadline
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Settle with matching polarity so the watchdog disarms.
    task automatic settle(input logic [7:0] l, input logic [7:0] h);
        cmp = pol; comm = 1'b0; lo = l; hi = h;
        repeat (20) @(negedge clk);
    endtask

    // Pulse commutate_i; returns at the negedge where the counter is 0.
    task automatic kick();
        comm = 1'b1;
        @(negedge clk);
        comm = 1'b0;
    endtask

    task automatic run_vec(input logic [7:0] l, input logic [7:0] h, input logic [7:0] m);
        int  le;
        bit  expf;
        settle(l, h);
        chk("R9 error flag", int'(err), int'(!(l < h)));
        le   = (l < h) ? int'(l) : ((h == 0) ? 0 : int'(h) - 1);
        expf = !((int'(m) >= le) && (m <= h));
        cmp  = ~pol;
        kick();
        for (int k = 0; k <= int'(h) + 1; k++) begin
            if (k > 0) @(negedge clk);
            cmp = (k == int'(m)) ? pol : ~pol;
            #1;
            chk("R2 blank window", int'(blank), int'(k < le));
            chk("R3 masked output", int'(masked), (k < le) ? 0 : int'(cmp));
            chk("R4 forced pulse", int'(force_c), int'(expf && (k == int'(h) + 1)));
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1 blank in reset", int'(blank), 0);
        chk("R1 force in reset", int'(force_c), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp = 1'b1; #1;
        chk("R1 err after reset", int'(err), 0);
        chk("R1 masked follows", int'(masked), 1);
        cmp = 1'b0; #1;
        chk("R1 masked follows", int'(masked), 0);
        repeat (40) @(negedge clk);
        chk("R1 no force before commutation", int'(force_c), 0);

        // Table walk
        for (int v = 0; v < 10; v++)
            run_vec(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);

        // R5: repeated forced steps every H+2 cycles
        settle(8'd2, 8'd5);
        cmp = ~pol;
        kick();
        for (int k = 0; k <= 14; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            chk("R5 repeat blank", int'(blank), int'((k % 7) < 2));
            chk("R5 repeat force", int'(force_c), int'((k % 7) == 6));
        end

        // R8: normal commutation on the expiry edge suppresses the pulse
        settle(8'd2, 8'd5);
        cmp = ~pol;
        kick();
        repeat (5) @(negedge clk);
        comm = 1'b1;
        @(negedge clk);
        comm = 1'b0;
        #1;
        chk("R8 force suppressed", int'(force_c), 0);
        chk("R8 restart blanks", int'(blank), 1);
        repeat (6) @(negedge clk);
        #1;
        chk("R8 later deadline fires", int'(force_c), 1);

        // R6: after a match no pulse and no wrap
        settle(8'd2, 8'd5);
        kick();
        for (int k = 0; k < 30; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            chk("R6 disarmed no force", int'(force_c), 0);
            chk("R6 saturated no blank", int'(blank), int'(k < 2));
        end

        // R1: reset during blanking
        settle(8'd6, 8'd20);
        cmp = ~pol;
        kick();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 reset clears blank", int'(blank), 0);
        chk("R1 reset clears force", int'(force_c), 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        #1;
        chk("R1 no pending event after reset", int'(force_c), 0);

        finish_run();
    end

endmodule